// File: doc/BRIEF.md
# Parallel-Port to JTAG Byte Shifter

This block is the engine of a host-side JTAG probe. A host on an EPP-style parallel port loads one byte that holds a sequence of test-mode-select values and one byte of test data. The address strobe carries the mode byte and the data strobe carries the data byte. The data byte starts a burst of exactly eight test-clock pulses. In each pulse the engine drives one mode bit and one data bit toward the target TAP and samples one bit returned by the target. When the burst ends, the eight returned bits are kept as a byte. The host reads that byte with a data-strobe read cycle, or reads a small status byte with an address-strobe read cycle.

The test clock is made by dividing the system clock. Each half period lasts `HALF_DIV` system cycles. The test clock stays low whenever no burst is running. The three port controls and the port bus pass through synchronisers before the engine uses them. A host cycle takes effect on the rising (releasing) edge of its strobe. Short sequences are sent as whole bytes with zeros in the unused high positions. The shift registers fill with zeros as they empty.

Top module: `ppJtagEngine`

## Requirements
- R1: While `rstN` is low and after its release: `tck` = 0, `tms` = 1 (the idle level), `tdi` = 0, and `busy`, `done` and `overrun` are all 0.
- R2: Two kinds of host write are recognised when the strobe is released with `writeN` = 0. Releasing `addrStbN` loads the port byte as the TMS sequence. Releasing `dataStbN` loads the port byte as the TDI byte, raises `busy` and starts a burst.
- R3: A burst has exactly eight rising edges of `tck`. Each `tck` period is 2*HALF_DIV system clocks, and each high phase lasts HALF_DIV system clocks. `tck` is 0 whenever `busy` is 0.
- R4: Bit 0 of the TMS and TDI bytes is presented at the first rising edge of `tck`, bit 1 at the second, and so on. `tms` and `tdi` change only together with a falling edge of `tck`, so they are stable at every rising edge.
- R5: `tdoIn` is sampled at each rising edge of `tck`. The first sample lands in bit 0 of the received byte and the eighth sample lands in bit 7.
- R6: After the eighth `tck` pulse has fallen, `busy` drops and `done` rises in the same cycle. `tms` then returns to 1 and `tdi` returns to 0.
- R7: A read cycle on the data strobe (`writeN` = 1, `dataStbN` low) raises `hostDataOe` and drives the received byte on `hostDataOut`. Releasing that strobe clears `done`.
- R8: A read cycle on the address strobe drives the status byte on `hostDataOut`: bit 0 is busy, bit 1 is done, bit 2 is overrun, and the other bits are 0. Releasing that strobe clears `overrun`.
- R9: A host write of either kind that completes while `busy` is 1 has no effect on the bits being shifted and sets `overrun`.
- R10: Pulling `rstN` low during a burst aborts it at once and gives the R1 state. A burst started afterwards runs normally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| hostDataIn | input | BITS | Port bus, host to engine |
| dataStbN | input | 1 | Data strobe, active low |
| addrStbN | input | 1 | Address strobe, active low |
| writeN | input | 1 | 0 = host write cycle, 1 = host read cycle |
| hostDataOut | output | BITS | Port bus, engine to host |
| hostDataOe | output | 1 | High while a read cycle is active |
| tck | output | 1 | Test clock to the target |
| tms | output | 1 | Test mode select to the target |
| tdi | output | 1 | Test data to the target |
| tdoIn | input | 1 | Test data from the target |
| busy | output | 1 | Burst in progress |
| done | output | 1 | Received byte ready |
| overrun | output | 1 | Sticky: a write arrived while busy |

## Verification
The bench builds the engine with HALF_DIV = 2 and BITS = 8. With these values a burst lasts 32 system clocks, which is long enough for a full host write cycle to land inside it, so the overrun case can be reached. A transfer is also short enough that many random byte triples fit in the run. A model of the target on the bench side records `tms` and `tdi` at each `tck` rise, drives `tdoIn` on each fall and times the spacing of the rises, so the bit order and the divider ratio are checked without counting cycles inside the design.

// File: rtl/ppJtagPkg.sv
package ppJtagPkg;

  // Strobes from the control FSM to the shift datapath.
  typedef struct packed {
    logic loadTms;     // capture the port byte as the TMS sequence
    logic loadTdi;     // capture the port byte as the TDI byte
    logic shiftOut;    // advance TMS/TDI to the next bit (tck falling)
    logic captureTdo;  // sample target data into the receive byte (tck rising)
  } pathCtl_t;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_LOW  = 2'd1,
    ST_HIGH = 2'd2
  } shiftState_t;

  // Bit positions inside the host-visible status byte.
  localparam int STAT_BUSY_BIT    = 0;
  localparam int STAT_DONE_BIT    = 1;
  localparam int STAT_OVERRUN_BIT = 2;

endpackage

// File: rtl/ppJtagSync.sv
module ppJtagSync #(
  parameter int WIDTH  = 1,
  parameter int STAGES = 2,
  parameter logic [WIDTH-1:0] RESET_VAL = '0
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] dout
);

  logic [WIDTH-1:0] stage [STAGES];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < STAGES; i++) stage[i] <= RESET_VAL;
    end else begin
      stage[0] <= din;
      for (int i = 1; i < STAGES; i++) stage[i] <= stage[i-1];
    end
  end

  assign dout = stage[STAGES-1];

endmodule

// File: rtl/ppJtagCtrl.sv
module ppJtagCtrl
  import ppJtagPkg::*;
#(
  parameter int HALF_DIV    = 4,
  parameter int BITS        = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic     clk,
  input  logic     rstN,
  input  logic     dataStbN,
  input  logic     addrStbN,
  input  logic     writeN,
  output pathCtl_t ctl,
  output logic     tck,
  output logic     busy,
  output logic     done,
  output logic     overrun,
  output logic     readActive,
  output logic     statusSel
);

  localparam int PH_W = $clog2(HALF_DIV) + 1;
  localparam int BC_W = $clog2(BITS) + 1;
  localparam logic [PH_W-1:0] PH_LAST  = PH_W'(HALF_DIV - 1);
  localparam logic [BC_W-1:0] BIT_LAST = BC_W'(BITS - 1);

  logic [2:0] syncCtl;
  logic sWriteN, sAddrN, sDataN;
  logic pAddrN, pDataN;
  logic dataRise, addrRise;
  logic dataWr, addrWr, dataRd, addrRd;
  logic lastPhase, lastBit;

  shiftState_t     state;
  logic [PH_W-1:0] phaseCnt;
  logic [BC_W-1:0] bitCnt;

  ppJtagSync #(.WIDTH(3), .STAGES(SYNC_STAGES), .RESET_VAL(3'b111)) ctlSync (
    .clk (clk),
    .rstN(rstN),
    .din ({writeN, addrStbN, dataStbN}),
    .dout(syncCtl)
  );

  assign {sWriteN, sAddrN, sDataN} = syncCtl;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pAddrN <= 1'b1;
      pDataN <= 1'b1;
    end else begin
      pAddrN <= sAddrN;
      pDataN <= sDataN;
    end
  end

  // A host cycle completes when its strobe is released.
  assign dataRise = sDataN & ~pDataN;
  assign addrRise = sAddrN & ~pAddrN;
  assign dataWr   = dataRise & ~sWriteN;
  assign addrWr   = addrRise & ~sWriteN;
  assign dataRd   = dataRise &  sWriteN;
  assign addrRd   = addrRise &  sWriteN;

  assign readActive = sWriteN & (~sDataN | ~sAddrN);
  assign statusSel  = ~sAddrN;

  assign lastPhase = (phaseCnt == PH_LAST);
  assign lastBit   = (bitCnt == BIT_LAST);

  always_comb begin
    ctl            = '0;
    ctl.loadTms    = addrWr & ~busy;
    ctl.loadTdi    = dataWr & ~busy;
    ctl.captureTdo = (state == ST_LOW)  && lastPhase;
    ctl.shiftOut   = (state == ST_HIGH) && lastPhase;
  end

  // Burst sequencer: low half, rising edge, high half, falling edge.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state    <= ST_IDLE;
      phaseCnt <= '0;
      bitCnt   <= '0;
      tck      <= 1'b0;
      busy     <= 1'b0;
      done     <= 1'b0;
    end else begin
      unique case (state)
        ST_IDLE: begin
          tck <= 1'b0;
          if (ctl.loadTdi) begin
            state    <= ST_LOW;
            phaseCnt <= '0;
            bitCnt   <= '0;
            busy     <= 1'b1;
            done     <= 1'b0;
          end else if (dataRd) begin
            done <= 1'b0;
          end
        end
        ST_LOW: begin
          if (lastPhase) begin
            tck      <= 1'b1;
            phaseCnt <= '0;
            state    <= ST_HIGH;
          end else begin
            phaseCnt <= phaseCnt + 1'b1;
          end
        end
        ST_HIGH: begin
          if (lastPhase) begin
            tck      <= 1'b0;
            phaseCnt <= '0;
            if (lastBit) begin
              state <= ST_IDLE;
              busy  <= 1'b0;
              done  <= 1'b1;
            end else begin
              bitCnt <= bitCnt + 1'b1;
              state  <= ST_LOW;
            end
          end else begin
            phaseCnt <= phaseCnt + 1'b1;
          end
        end
        default: begin
          state <= ST_IDLE;
          tck   <= 1'b0;
          busy  <= 1'b0;
        end
      endcase
    end
  end

  // Sticky overrun: set by a write during a burst, cleared by a status read.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      overrun <= 1'b0;
    end else if ((dataWr | addrWr) & busy) begin
      overrun <= 1'b1;
    end else if (addrRd) begin
      overrun <= 1'b0;
    end
  end

endmodule

// File: rtl/ppJtagPath.sv
module ppJtagPath
  import ppJtagPkg::*;
#(
  parameter int   BITS        = 8,
  parameter int   SYNC_STAGES = 2,
  parameter logic TMS_IDLE    = 1'b1
) (
  input  logic            clk,
  input  logic            rstN,
  input  pathCtl_t        ctl,
  input  logic [BITS-1:0] hostDataIn,
  input  logic            busy,
  input  logic            tdoIn,
  input  logic            statusSel,
  input  logic [BITS-1:0] statusWord,
  output logic [BITS-1:0] hostDataOut,
  output logic            tms,
  output logic            tdi
);

  logic [BITS-1:0] busSync;
  logic [BITS-1:0] tmsShift, tdiShift, rxShift;

  // The bus goes through the same number of stages as the strobes.
  ppJtagSync #(.WIDTH(BITS), .STAGES(SYNC_STAGES), .RESET_VAL('0)) busSyncInst (
    .clk (clk),
    .rstN(rstN),
    .din (hostDataIn),
    .dout(busSync)
  );

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      tmsShift <= '0;
      tdiShift <= '0;
    end else begin
      if (ctl.loadTms)       tmsShift <= busSync;
      else if (ctl.shiftOut) tmsShift <= {1'b0, tmsShift[BITS-1:1]};
      if (ctl.loadTdi)       tdiShift <= busSync;
      else if (ctl.shiftOut) tdiShift <= {1'b0, tdiShift[BITS-1:1]};
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)               rxShift <= '0;
    else if (ctl.captureTdo) rxShift <= {tdoIn, rxShift[BITS-1:1]};
  end

  assign tms         = busy ? tmsShift[0] : TMS_IDLE;
  assign tdi         = busy ? tdiShift[0] : 1'b0;
  assign hostDataOut = statusSel ? statusWord : rxShift;

endmodule

// File: rtl/ppJtagEngine.sv
module ppJtagEngine
  import ppJtagPkg::*;
#(
  parameter int   HALF_DIV    = 4,
  parameter int   BITS        = 8,
  parameter int   SYNC_STAGES = 2,
  parameter logic TMS_IDLE    = 1'b1
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic [BITS-1:0] hostDataIn,
  input  logic            dataStbN,
  input  logic            addrStbN,
  input  logic            writeN,
  output logic [BITS-1:0] hostDataOut,
  output logic            hostDataOe,
  output logic            tck,
  output logic            tms,
  output logic            tdi,
  input  logic            tdoIn,
  output logic            busy,
  output logic            done,
  output logic            overrun
);

  pathCtl_t        ctl;
  logic            statusSel;
  logic [BITS-1:0] statusWord;

  ppJtagCtrl #(.HALF_DIV(HALF_DIV), .BITS(BITS), .SYNC_STAGES(SYNC_STAGES)) ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .dataStbN  (dataStbN),
    .addrStbN  (addrStbN),
    .writeN    (writeN),
    .ctl       (ctl),
    .tck       (tck),
    .busy      (busy),
    .done      (done),
    .overrun   (overrun),
    .readActive(hostDataOe),
    .statusSel (statusSel)
  );

  always_comb begin
    statusWord                   = '0;
    statusWord[STAT_BUSY_BIT]    = busy;
    statusWord[STAT_DONE_BIT]    = done;
    statusWord[STAT_OVERRUN_BIT] = overrun;
  end

  ppJtagPath #(.BITS(BITS), .SYNC_STAGES(SYNC_STAGES), .TMS_IDLE(TMS_IDLE)) path (
    .clk        (clk),
    .rstN       (rstN),
    .ctl        (ctl),
    .hostDataIn (hostDataIn),
    .busy       (busy),
    .tdoIn      (tdoIn),
    .statusSel  (statusSel),
    .statusWord (statusWord),
    .hostDataOut(hostDataOut),
    .tms        (tms),
    .tdi        (tdi)
  );

endmodule

// File: rtl/ppJtagChecker.sv
module ppJtagChecker #(
  parameter int   HALF_DIV = 4,
  parameter logic TMS_IDLE = 1'b1
) (
  input logic clk,
  input logic rstN,
  input logic tck,
  input logic tms,
  input logic tdi,
  input logic busy,
  input logic done
);

  int highRun;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)    highRun <= 0;
    else if (tck) highRun <= highRun + 1;
    else          highRun <= 0;
  end

  AST_TCK_IDLE_LOW: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> !tck); // R3

  AST_TCK_HIGH_WIDTH: assert property (@(posedge clk) disable iff (!rstN)
    tck |-> (highRun < HALF_DIV)); // R3

  AST_PINS_STABLE_AT_RISE: assert property (@(posedge clk) disable iff (!rstN)
    $rose(tck) |-> ($stable(tms) && $stable(tdi))); // R4

  AST_IDLE_PIN_LEVELS: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> (tms == TMS_IDLE && !tdi)); // R6

  AST_DONE_EXCLUDES_BUSY: assert property (@(posedge clk) disable iff (!rstN)
    done |-> !busy); // R6

  AST_BUSY_FALL_DONE: assert property (@(posedge clk) disable iff (!rstN)
    $fell(busy) |-> done); // R6

endmodule

bind ppJtagEngine ppJtagChecker #(.HALF_DIV(HALF_DIV), .TMS_IDLE(TMS_IDLE)) chk (
  .clk (clk),
  .rstN(rstN),
  .tck (tck),
  .tms (tms),
  .tdi (tdi),
  .busy(busy),
  .done(done)
);

// File: tb/ppJtagEngine_test.sv
`timescale 1ns/1ps
module ppJtagEngine_test;

  localparam int HALF_DIV = 2;
  localparam int BITS     = 8;
  localparam longint PERIOD_NS = 2 * HALF_DIV * 4;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [BITS-1:0] hostDataIn = '0;
  logic dataStbN = 1'b1, addrStbN = 1'b1, writeN = 1'b1;
  logic [BITS-1:0] hostDataOut;
  logic hostDataOe, tck, tms, tdi, busy, done, overrun;
  logic tdoIn = 1'b0;

  int checks = 0;
  int failures = 0;

  always #2 clk = ~clk;

  ppJtagEngine #(.HALF_DIV(HALF_DIV), .BITS(BITS)) uut (
    .clk(clk), .rstN(rstN), .hostDataIn(hostDataIn), .dataStbN(dataStbN),
    .addrStbN(addrStbN), .writeN(writeN), .hostDataOut(hostDataOut),
    .hostDataOe(hostDataOe), .tck(tck), .tms(tms), .tdi(tdi), .tdoIn(tdoIn),
    .busy(busy), .done(done), .overrun(overrun)
  );

  // Target model: samples pins on tck rise, moves TDO on tck fall.
  int riseIdx = 0;
  int periodBad = 0;
  longint lastRise = 0;
  logic [BITS-1:0] recTms = '0, recTdi = '0, tdoPat = '0;

  always @(posedge tck) begin
    if (riseIdx < BITS) begin
      recTms[riseIdx] = tms;
      recTdi[riseIdx] = tdi;
    end
    if (riseIdx > 0 && ($time - lastRise) != PERIOD_NS) periodBad++;
    lastRise = $time;
    riseIdx++;
  end

  always @(negedge tck) tdoIn = (riseIdx < BITS) ? tdoPat[riseIdx] : 1'b0;

  function automatic logic [BITS-1:0] expStatus(input bit b, input bit d, input bit o);
    logic [BITS-1:0] s = '0;
    s[0] = b; s[1] = d; s[2] = o;
    return s;
  endfunction

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic finishRun();
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  task automatic hostCycle(input bit isAddr, input bit isWrite, input logic [BITS-1:0] d,
                           output logic [BITS-1:0] rd, output logic oe);
    @(negedge clk);
    writeN = !isWrite;
    hostDataIn = d;
    repeat (2) @(negedge clk);
    if (isAddr) addrStbN = 1'b0; else dataStbN = 1'b0;
    repeat (5) @(negedge clk);
    rd = hostDataOut;
    oe = hostDataOe;
    addrStbN = 1'b1;
    dataStbN = 1'b1;
    repeat (5) @(negedge clk);
    writeN = 1'b1;
  endtask

  task automatic waitIdle();
    for (int n = 0; n < 400; n++) begin
      @(negedge clk);
      if (!busy) break;
    end
  endtask

  task automatic runXfer(input logic [BITS-1:0] tmsB, input logic [BITS-1:0] tdiB,
                         input logic [BITS-1:0] tdoB, input string tag);
    logic [BITS-1:0] rd;
    logic oe;
    tdoPat = tdoB;
    riseIdx = 0;
    periodBad = 0;
    tdoIn = tdoB[0];
    hostCycle(1'b1, 1'b1, tmsB, rd, oe);
    hostCycle(1'b0, 1'b1, tdiB, rd, oe);
    check(busy === 1'b1, {"R2 busy after data write ", tag}, busy, 1);
    waitIdle();
    check(recTms === tmsB, {"R2 R4 tms bits ", tag}, recTms, tmsB);
    check(recTdi === tdiB, {"R2 R4 tdi bits ", tag}, recTdi, tdiB);
    check(riseIdx == BITS && periodBad == 0, {"R3 tck pulses/period ", tag}, riseIdx, BITS);
    check(done === 1'b1 && tck === 1'b0, {"R6 done, tck low ", tag}, {done, tck}, 2'b10);
    check(tms === 1'b1 && tdi === 1'b0, {"R6 idle pins ", tag}, {tms, tdi}, 2'b10);
    hostCycle(1'b0, 1'b0, '0, rd, oe);
    check(rd === tdoB && oe === 1'b1, {"R5 R7 received byte ", tag}, rd, tdoB);
    check(done === 1'b0, {"R7 done cleared ", tag}, done, 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired actual=running expected=finished");
    finishRun();
  end

  initial begin
    logic [BITS-1:0] rd;
    logic oe;
    int unused;
    unused = $urandom(32'h0000_5eed);

    repeat (3) @(negedge clk);
    check(tck === 0 && tms === 1 && tdi === 0, "R1 pins in reset", {tck, tms, tdi}, 3'b010);
    check(busy === 0 && done === 0 && overrun === 0, "R1 flags in reset",
          {busy, done, overrun}, 0);
    rstN = 1'b1;
    repeat (4) @(negedge clk);
    check(tck === 0 && tms === 1 && !busy && !done && !overrun, "R1 after release",
          {tck, tms, busy}, 3'b010);

    // Directed: short TMS sequence with zero padding, alternating data.
    runXfer(8'h03, 8'hA5, 8'h3C, "dir0");
    runXfer(8'h80, 8'h01, 8'h81, "dir1");
    runXfer(8'hFF, 8'h00, 8'hFF, "dir2");

    // Overrun: writes of both kinds land during a burst.
    tdoPat = 8'h5A; riseIdx = 0; periodBad = 0; tdoIn = 1'b0;
    hostCycle(1'b1, 1'b1, 8'h1F, rd, oe);
    hostCycle(1'b0, 1'b1, 8'hC3, rd, oe);
    hostCycle(1'b0, 1'b1, 8'h3C, rd, oe);
    hostCycle(1'b1, 1'b1, 8'hE0, rd, oe);
    check(overrun === 1'b1, "R9 overrun set", overrun, 1);
    waitIdle();
    check(recTdi === 8'hC3, "R9 tdi unaffected", recTdi, 8'hC3);
    check(recTms === 8'h1F, "R9 tms unaffected", recTms, 8'h1F);
    hostCycle(1'b1, 1'b0, '0, rd, oe);
    check(rd === expStatus(0, 1, 1) && oe === 1, "R8 status with overrun", rd, expStatus(0, 1, 1));
    hostCycle(1'b1, 1'b0, '0, rd, oe);
    check(rd === expStatus(0, 1, 0), "R8 overrun cleared by status read", rd, expStatus(0, 1, 0));
    hostCycle(1'b0, 1'b0, '0, rd, oe);
    check(rd === 8'h5A, "R5 byte after overrun", rd, 8'h5A);

    // Status while busy.
    tdoPat = 8'h00; riseIdx = 0;
    hostCycle(1'b1, 1'b1, 8'h00, rd, oe);
    hostCycle(1'b0, 1'b1, 8'h55, rd, oe);
    hostCycle(1'b1, 1'b0, '0, rd, oe);
    check(rd === expStatus(1, 0, 0), "R8 status while busy", rd, expStatus(1, 0, 0));
    waitIdle();

    // Reset in the middle of a burst.
    tdoPat = 8'hFF; riseIdx = 0;
    hostCycle(1'b1, 1'b1, 8'hFF, rd, oe);
    hostCycle(1'b0, 1'b1, 8'hFF, rd, oe);
    @(negedge clk);
    rstN = 1'b0;
    @(negedge clk);
    check(tck === 0 && tms === 1 && tdi === 0 && !busy && !done, "R10 abort on reset",
          {tck, tms, tdi, busy}, 4'b0100);
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    repeat (3) @(negedge clk);
    runXfer(8'h96, 8'h69, 8'hC5, "R10 after abort");

    // Random transfers.
    for (int i = 0; i < 16; i++) begin
      runXfer(BITS'($urandom), BITS'($urandom), BITS'($urandom), "rand");
    end

    finishRun();
  end

endmodule